// File: doc/BRIEF.md
# Word-Complete Interrupt Status Controller

This block collects the interrupt events of a serial flash controller and turns them into one level-sensitive interrupt line for the processor. The transfer engine supplies two single-cycle event pulses: one when a word has been shifted and one when a whole frame has finished. Each event latches into a raw status bit. A separate enable bit per source decides whether that pending status reaches the interrupt line.

Software reaches the block through a simple register port with an address, a write strobe, write data and combinational read data. Enables are never written directly. One address sets enable bits and another clears them, so a handler can mask its own source without a read-modify-write. The masked status view is cleared by writing ones to it. The raw view can be written with ones to force an event for test.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset all raw status bits and all enable bits are zero, every register reads zero and irq_o is low.
- R2: A pulse on word_done_i sets raw status bit 1 and a pulse on frame_done_i sets raw status bit 0. Raw status is read at offset 0x20.
- R3: Writing to offset 0x28 sets each enable bit whose write-data bit is one (bit 1 word, bit 0 frame) and leaves bits written with zero unchanged. Reading 0x28 or 0x2C returns the current enables.
- R4: Writing to offset 0x2C clears each enable bit whose write-data bit is one and leaves bits written with zero unchanged.
- R5: Reading offset 0x24 returns raw status ANDed with the enables, which is zero when no enabled source is pending.
- R6: Writing to offset 0x24 clears each raw status bit whose write-data bit is one, whatever its enable. Bits written with zero stay as they were.
- R7: Writing to offset 0x20 sets each raw status bit whose write-data bit is one, so software can force an interrupt.
- R8: When an event pulse and a clearing write to 0x24 for the same bit land in one cycle, the bit is set after that cycle.
- R9: irq_o is high exactly when some raw status bit and its enable are both set. It follows a status or enable change in the cycle after the edge that stores it.
- R10: Addresses other than 0x20, 0x24, 0x28 and 0x2C read zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W (8) | Register byte offset |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Read data for addr_i, combinational |
| word_done_i | input | 1 | Word-complete event pulse |
| frame_done_i | input | 1 | Frame-complete event pulse |
| irq_o | output | 1 | Level interrupt to the processor |

## Verification
The hardest case to reach is an event and a clearing write on the same bit in the same cycle. The bench first makes the word-complete bit pending. It then drives word_done_i and the write to 0x24 in one cycle, and reads raw status back to show the bit stayed set. Masking is checked the same way at the port: the enable is dropped while the status is still pending, the interrupt line must fall, and raw status must still show the pending bit.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned N_SRC    = 2;
  localparam int unsigned FRAME_B  = 0;
  localparam int unsigned WORD_B   = 1;
  localparam int unsigned OFF_RAW  = 'h20;
  localparam int unsigned OFF_MSK  = 'h24;
  localparam int unsigned OFF_ENS  = 'h28;
  localparam int unsigned OFF_ENC  = 'h2C;

  typedef struct packed {
    logic raw_wr;
    logic msk_wr;
    logic ens_wr;
    logic enc_wr;
  } wsel_t;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_RAW,
    RD_MSK,
    RD_EN
  } rsel_e;
endpackage

// File: rtl/irq_addr_dec.sv
module irq_addr_dec
  import irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  output wsel_t             wsel_o,
  output rsel_e             rsel_o
);
  logic hit_raw, hit_msk, hit_ens, hit_enc;

  assign hit_raw = (addr_i == ADDR_W'(OFF_RAW));
  assign hit_msk = (addr_i == ADDR_W'(OFF_MSK));
  assign hit_ens = (addr_i == ADDR_W'(OFF_ENS));
  assign hit_enc = (addr_i == ADDR_W'(OFF_ENC));

  assign wsel_o.raw_wr = wr_en_i & hit_raw;
  assign wsel_o.msk_wr = wr_en_i & hit_msk;
  assign wsel_o.ens_wr = wr_en_i & hit_ens;
  assign wsel_o.enc_wr = wr_en_i & hit_enc;

  always_comb begin
    rsel_o = RD_NONE;
    if (hit_raw)                rsel_o = RD_RAW;
    else if (hit_msk)           rsel_o = RD_MSK;
    else if (hit_ens | hit_enc) rsel_o = RD_EN;
  end
endmodule

// File: rtl/irq_src_cell.sv
module irq_src_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic event_i,
  input  logic set_raw_i,
  input  logic clr_raw_i,
  input  logic set_en_i,
  input  logic clr_en_i,
  output logic raw_o,
  output logic en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_o <= 1'b0;
    end else if (event_i | set_raw_i) begin
      raw_o <= 1'b1;  // event beats a same-cycle clear
    end else if (clr_raw_i) begin
      raw_o <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       en_o <= 1'b0;
    else if (set_en_i) en_o <= 1'b1;
    else if (clr_en_i) en_o <= 1'b0;
  end
endmodule

// File: rtl/irq_rd_mux.sv
module irq_rd_mux
  import irq_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  rsel_e            rsel_i,
  input  logic [N_SRC-1:0] raw_i,
  input  logic [N_SRC-1:0] en_i,
  output logic [DATA_W-1:0] rdata_o
);
  always_comb begin
    rdata_o = '0;
    unique case (rsel_i)
      RD_RAW:  rdata_o[N_SRC-1:0] = raw_i;
      RD_MSK:  rdata_o[N_SRC-1:0] = raw_i & en_i;
      RD_EN:   rdata_o[N_SRC-1:0] = en_i;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              word_done_i,
  input  logic              frame_done_i,
  output logic              irq_o
);
  wsel_t            wsel;
  rsel_e            rsel;
  logic [N_SRC-1:0] ev;
  logic [N_SRC-1:0] raw_q;
  logic [N_SRC-1:0] en_q;
  logic             unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:N_SRC];

  always_comb begin
    ev          = '0;
    ev[WORD_B]  = word_done_i;
    ev[FRAME_B] = frame_done_i;
  end

  irq_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i),
    .wr_en_i(wr_en_i),
    .wsel_o (wsel),
    .rsel_o (rsel)
  );

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    irq_src_cell u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .event_i  (ev[i]),
      .set_raw_i(wsel.raw_wr & wdata_i[i]),
      .clr_raw_i(wsel.msk_wr & wdata_i[i]),
      .set_en_i (wsel.ens_wr & wdata_i[i]),
      .clr_en_i (wsel.enc_wr & wdata_i[i]),
      .raw_o    (raw_q[i]),
      .en_o     (en_q[i])
    );
  end

  irq_rd_mux #(.DATA_W(DATA_W)) u_rd (
    .rsel_i (rsel),
    .raw_i  (raw_q),
    .en_i   (en_q),
    .rdata_o(rdata_o)
  );

  assign irq_o = |(raw_q & en_q);
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk
  import irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              word_done_i,
  input logic              frame_done_i,
  input logic              irq_o,
  input logic [N_SRC-1:0]  raw_q,
  input logic [N_SRC-1:0]  en_q
);
  // R2
  word_sets_raw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_done_i |=> raw_q[WORD_B]);

  // R8
  frame_beats_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_done_i && wr_en_i && addr_i == ADDR_W'(OFF_MSK) && wdata_i[FRAME_B])
    |=> raw_q[FRAME_B]);

  // R3
  en_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(OFF_ENS) && wdata_i[WORD_B]) |=> en_q[WORD_B]);

  // R4
  en_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(OFF_ENC) && wdata_i[WORD_B]) |=> !en_q[WORD_B]);

  // R6
  raw_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(OFF_MSK) && wdata_i[WORD_B] && !word_done_i)
    |=> !raw_q[WORD_B]);

  // R9
  irq_vs_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(OFF_MSK)) |-> (irq_o == (rdata_o != '0)));

  // R10
  unmapped_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i != ADDR_W'(OFF_RAW) && addr_i != ADDR_W'(OFF_MSK) &&
     addr_i != ADDR_W'(OFF_ENS) && addr_i != ADDR_W'(OFF_ENC)) |-> (rdata_o == '0));
endmodule

bind irq_status_ctrl irq_status_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_irq_status_ctrl.sv
`timescale 1ns/1ps
module sim_irq_status_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr_i = '0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        word_done_i = 1'b0;
  logic        frame_done_i = 1'b0;
  logic        irq_o;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  irq_status_ctrl u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk_i);
    addr_i = a;
    #2 d = rdata_o;
  endtask

  task automatic pulse(input bit w, input bit f);
    @(negedge clk_i);
    word_done_i = w; frame_done_i = f;
    @(negedge clk_i);
    word_done_i = 1'b0; frame_done_i = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h20, d); chk("R1 raw", d, 0);
    rd(8'h24, d); chk("R1 masked", d, 0);
    rd(8'h28, d); chk("R1 enable", d, 0);
    chk("R1 irq", irq_o, 0);
  endtask

  task automatic t_events();
    logic [31:0] d;
    pulse(1, 0); rd(8'h20, d); chk("R2 word", d, 32'h2);
    pulse(0, 1); rd(8'h20, d); chk("R2 frame", d, 32'h3);
    rd(8'h24, d); chk("R5 none enabled", d, 0);
    chk("R9 masked off", irq_o, 0);
    wr(8'h24, 32'h3); rd(8'h20, d); chk("R6 clear both", d, 0);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    wr(8'h28, 32'h2); rd(8'h28, d); chk("R3 set word", d, 32'h2);
    wr(8'h28, 32'h0); rd(8'h2C, d); chk("R3 zero keeps", d, 32'h2);
    wr(8'h28, 32'h1); rd(8'h28, d); chk("R3 set frame", d, 32'h3);
    wr(8'h2C, 32'h0); rd(8'h28, d); chk("R4 zero keeps", d, 32'h3);
    wr(8'h2C, 32'h1); rd(8'h28, d); chk("R4 clear frame", d, 32'h2);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    pulse(0, 1); rd(8'h24, d); chk("R5 frame masked", d, 0);
    chk("R9 frame off", irq_o, 0);
    pulse(1, 0); rd(8'h24, d); chk("R5 word pending", d, 32'h2);
    chk("R9 word on", irq_o, 1);
    wr(8'h2C, 32'h2); chk("R9 masked drop", irq_o, 0);
    rd(8'h20, d); chk("R4 raw kept", d, 32'h3);
    wr(8'h28, 32'h2); chk("R9 re-enable", irq_o, 1);
    wr(8'h24, 32'h0); rd(8'h20, d); chk("R6 zero keeps", d, 32'h3);
    wr(8'h24, 32'h2); rd(8'h20, d); chk("R6 clear word", d, 32'h1);
    chk("R9 after clear", irq_o, 0);
    wr(8'h24, 32'h1);
  endtask

  task automatic t_force();
    logic [31:0] d;
    wr(8'h20, 32'h2); rd(8'h20, d); chk("R7 force", d, 32'h2);
    chk("R7 irq", irq_o, 1);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    @(negedge clk_i);
    word_done_i = 1'b1; addr_i = 8'h24; wdata_i = 32'h2; wr_en_i = 1'b1;
    @(negedge clk_i);
    word_done_i = 1'b0; wr_en_i = 1'b0; wdata_i = '0;
    rd(8'h20, d); chk("R8 event wins", d, 32'h2);
    wr(8'h24, 32'h2); rd(8'h20, d); chk("R8 later clear", d, 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(8'h30, 32'hFFFF_FFFF);
    rd(8'h20, d); chk("R10 raw kept", d, 0);
    rd(8'h28, d); chk("R10 en kept", d, 32'h2);
    rd(8'h30, d); chk("R10 reads zero", d, 0);
    rd(8'h00, d); chk("R10 low addr zero", d, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    t_reset();
    t_events();
    t_enable();
    t_irq();
    t_force();
    t_collide();
    t_unmapped();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule